// File: doc/BRIEF.md
# Eight-Channel PWM Generator with Pair Joining

The block drives eight PWM output pins from a small register bus. Each channel has an 8-bit period register, an 8-bit duty register and a bit in a shared enable register. One prescaler produces a clock-source tick at a selectable divide-by-2^k rate. Every channel counter advances on that tick and produces a left-aligned waveform. The output is high from the start of each period until the count reaches the duty value.

Two neighbouring channels can be joined into a single 16-bit channel. In a joined pair, the odd channel holds the low byte, owns the enable and drives the waveform. The even channel's pin is held low. A channel that is switched on starts at the next prescaler tick, not at once. While every enable bit is clear, the prescaler stays parked at zero.

Top module: `pwm_pair_gen`

## Requirements
- R1: The enable register sits at address 0, with bit n controlling channel n. It resets to 0x00 and can be written and read back at any time.
- R2: Register map:
  - Address 1 bits 3:0 are the join bits, with bit p joining channels 2p and 2p+1.
  - Address 2 bits 2:0 select the prescaler exponent k.
  - Addresses 8+n hold the period of channel n.
  - Addresses 16+n hold the duty of channel n.
  - Every other address reads 0.
- R3: While running, the prescaler issues one tick every 2^k clock cycles, and each enabled channel counter advances once per tick.
- R4: While the whole enable register is zero, the prescaler is held at zero and issues no ticks. After it restarts with k=3, the first tick comes on the 8th clock edge after the enabling write.
- R5: A newly enabled channel's output stays low until the next prescaler tick. On that tick the channel becomes active with its count at zero.
- R6: An active channel counts 0 up to period-1 and then wraps to 0. A period of 0 or 1 gives a one-tick period. The output is high while count < duty.
- R7: A disabled channel outputs low and its counter is cleared. All outputs are low after reset.
- R8: When join bit p is set, channels 2p and 2p+1 form one 16-bit channel:
  - The period is {period[2p], period[2p+1]}.
  - The duty is {duty[2p], duty[2p+1]}.
  - The waveform appears on pin 2p+1.
- R9: In a joined pair, only enable bit 2p+1 controls the channel. Enable bit 2p has no effect, and pin 2p is held low.
- R10: A duty value at or above the period gives a constant high output. A duty of 0 gives a constant low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pwm_o | output | 8 | PWM outputs, bit n is channel n |

## Verification
The bench times the first tick after a fully idle period. A prescaler that keeps running while all channels are disabled would move that first edge, so the measured delay would differ from the expected one. It watches the first cycles after an enable: an output that follows the enable bit straight away would go high before the tick. In joined pairs it counts high cycles against a 300-cycle period, and it checks that the even enable leaves every pin low. A wrong carry between the bytes, or the wrong pin or enable bit, would change those counts. Duty values at or above the period, and a duty of zero, are checked for stuck outputs, which would catch an off-by-one in the compare.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned AW = 5;
  localparam logic [AW-1:0] A_EN   = 5'd0;
  localparam logic [AW-1:0] A_CAT  = 5'd1;
  localparam logic [AW-1:0] A_PS   = 5'd2;
  localparam logic [AW-1:0] A_PER  = 5'd8;
  localparam logic [AW-1:0] A_DUTY = 5'd16;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [PSW-1:0] sel_i,
  output logic           tick_o
);
  localparam int unsigned DW = 1 << PSW;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] mask;

  assign mask   = (DW'(1) << sel_i) - DW'(1);
  assign tick_o = run_i && ((cnt_q & mask) == mask);

  // parked at zero while idle so restart timing is fixed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + DW'(1);
    else             cnt_q <= '0;
  end

  AST_PRESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R4
  AST_PRESC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cnt_q == $past(cnt_q) + DW'(1))); // R3
  AST_NO_IDLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !$past(tick_o)); // R4
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cat_i,
  input  logic [1:0]    en_i,      // [0] even, [1] odd
  input  logic [CW-1:0] per_e_i,
  input  logic [CW-1:0] per_o_i,
  input  logic [CW-1:0] duty_e_i,
  input  logic [CW-1:0] duty_o_i,
  output logic [1:0]    pwm_o
);
  localparam int unsigned WW = 2 * CW;

  logic [CW-1:0] cnt_e_q, cnt_o_q;
  logic          act_e_q, act_o_q;
  logic          eff_e, eff_o;
  logic [WW-1:0] wide_cnt, wide_per, wide_duty;

  function automatic logic [CW-1:0] step_n(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return (p == '0 || c >= p - CW'(1)) ? '0 : c + CW'(1);
  endfunction

  function automatic logic [WW-1:0] step_w(input logic [WW-1:0] c, input logic [WW-1:0] p);
    return (p == '0 || c >= p - WW'(1)) ? '0 : c + WW'(1);
  endfunction

  assign eff_o     = en_i[1];
  assign eff_e     = en_i[0] && !cat_i;
  assign wide_cnt  = {cnt_e_q, cnt_o_q};
  assign wide_per  = {per_e_i, per_o_i};
  assign wide_duty = {duty_e_i, duty_o_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_e_q <= '0;
      cnt_o_q <= '0;
      act_e_q <= 1'b0;
      act_o_q <= 1'b0;
    end else if (cat_i) begin
      act_e_q <= 1'b0;
      if (!eff_o) begin
        act_o_q <= 1'b0;
        cnt_o_q <= '0;
        cnt_e_q <= '0;
      end else if (tick_i) begin
        act_o_q <= 1'b1;
        if (act_o_q) {cnt_e_q, cnt_o_q} <= step_w(wide_cnt, wide_per);
      end
    end else begin
      if (!eff_o) begin
        act_o_q <= 1'b0;
        cnt_o_q <= '0;
      end else if (tick_i) begin
        act_o_q <= 1'b1;
        if (act_o_q) cnt_o_q <= step_n(cnt_o_q, per_o_i);
      end
      if (!eff_e) begin
        act_e_q <= 1'b0;
        cnt_e_q <= '0;
      end else if (tick_i) begin
        act_e_q <= 1'b1;
        if (act_e_q) cnt_e_q <= step_n(cnt_e_q, per_e_i);
      end
    end
  end

  assign pwm_o[1] = act_o_q && (cat_i ? (wide_cnt < wide_duty) : (cnt_o_q < duty_o_i));
  assign pwm_o[0] = !cat_i && act_e_q && (cnt_e_q < duty_e_i);

  AST_EN_SYNC_O: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_o_q) |-> $past(tick_i)); // R5
  AST_EN_SYNC_E: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_e_q) |-> $past(tick_i)); // R5
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[1] |=> !pwm_o[1]); // R7
  AST_EVEN_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cat_i) |-> !act_e_q); // R9
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 8,
  parameter int unsigned PSW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   rdata_o,
  output logic [NCH-1:0]  pwm_o
);
  localparam int unsigned NP = NCH / 2;

  logic [NCH-1:0] en_q;
  logic [NP-1:0]  cat_q;
  logic [PSW-1:0] ps_q;
  logic [CW-1:0]  per_q  [NCH];
  logic [CW-1:0]  duty_q [NCH];
  logic           tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cat_q <= '0;
      ps_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else if (wr_i) begin
      if (addr_i == A_EN)  en_q  <= wdata_i[NCH-1:0];
      if (addr_i == A_CAT) cat_q <= wdata_i[NP-1:0];
      if (addr_i == A_PS)  ps_q  <= wdata_i[PSW-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (addr_i == A_PER + AW'(i))  per_q[i]  <= wdata_i;
        if (addr_i == A_DUTY + AW'(i)) duty_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_EN)  rdata_o[NCH-1:0] = en_q;
    if (addr_i == A_CAT) rdata_o[NP-1:0]  = cat_q;
    if (addr_i == A_PS)  rdata_o[PSW-1:0] = ps_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == A_PER + AW'(i))  rdata_o = per_q[i];
      if (addr_i == A_DUTY + AW'(i)) rdata_o = duty_q[i];
    end
  end

  pwm_prescaler #(.PSW(PSW)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (|en_q),
    .sel_i  (ps_q),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    pwm_pair #(.CW(CW)) u_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cat_i    (cat_q[p]),
      .en_i     (en_q[2*p+1:2*p]),
      .per_e_i  (per_q[2*p]),
      .per_o_i  (per_q[2*p+1]),
      .duty_e_i (duty_q[2*p]),
      .duty_o_i (duty_q[2*p+1]),
      .pwm_o    (pwm_o[2*p+1:2*p])
    );
  end

  AST_IDLE_OUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> (pwm_o == '0)); // R7
endmodule

// File: tb/pwm_pair_gen_tb.sv
module pwm_pair_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pwm_o;

  pwm_pair_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference model
  int m_pc, m_en, m_cat, m_ps;
  int m_per[8], m_duty[8], m_act[8], m_cnt[8];
  int mask_m;
  bit tick_m;

  task automatic m_upd(input int ch, input bit eff, input int per);
    if (!eff) begin
      m_act[ch] = 0; m_cnt[ch] = 0;
    end else if (tick_m) begin
      if (m_act[ch] != 0) m_cnt[ch] = (per == 0 || m_cnt[ch] >= per - 1) ? 0 : m_cnt[ch] + 1;
      m_act[ch] = 1;
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0; m_en = 0; m_cat = 0; m_ps = 0;
      for (int i = 0; i < 8; i++) begin
        m_per[i] = 0; m_duty[i] = 0; m_act[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      mask_m = (1 << m_ps) - 1;
      tick_m = (m_en != 0) && ((m_pc & mask_m) == mask_m);
      m_pc = (m_en != 0) ? (m_pc + 1) % 256 : 0;
      for (int p = 0; p < 4; p++) begin
        if (m_cat[p]) begin
          m_act[2*p] = 0; m_cnt[2*p] = 0;
          m_upd(2*p+1, m_en[2*p+1], m_per[2*p] * 256 + m_per[2*p+1]);
        end else begin
          m_upd(2*p+1, m_en[2*p+1], m_per[2*p+1]);
          m_upd(2*p, m_en[2*p], m_per[2*p]);
        end
      end
      if (wr_i) begin
        if (addr_i == 0) m_en = wdata_i;
        if (addr_i == 1) m_cat = wdata_i & 4'hF;
        if (addr_i == 2) m_ps = wdata_i & 3'h7;
        if (addr_i >= 8 && addr_i < 16) m_per[addr_i - 8] = wdata_i;
        if (addr_i >= 16 && addr_i < 24) m_duty[addr_i - 16] = wdata_i;
      end
    end
  end

  function automatic bit m_out(input int ch);
    int p;
    p = ch / 2;
    if (m_cat[p]) begin
      if (ch % 2 == 0) return 0;
      return m_act[ch] != 0 && m_cnt[ch] < m_duty[ch-1] * 256 + m_duty[ch];
    end
    return m_act[ch] != 0 && m_cnt[ch] < m_duty[ch];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [7:0] e;
      for (int i = 0; i < 8; i++) e[i] = m_out(i);
      chk(pwm_o == e, "R3 R5 R6 R7 R8 R9 R10 model", pwm_o, e);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 5'(a); wdata_i = 8'(d);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk_i);
    addr_i = 5'(a);
    #1 d = rdata_o;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      #1 if (pwm_o[ch]) hi++;
    end
  endtask

  initial begin
    int d, n, hi;
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 0, "R7 reset outputs", pwm_o, 0);
    rd(0, d); chk(d == 0, "R1 enable reset", d, 0);
    rst_ni = 1'b1;

    wr(0, 8'hA5); rd(0, d); chk(d == 8'hA5, "R1 enable readback", d, 8'hA5);
    wr(0, 0);     rd(0, d); chk(d == 0, "R1 enable clear", d, 0);
    wr(1, 8'hF5); rd(1, d); chk(d == 5, "R2 join readback", d, 5);
    wr(1, 0);
    wr(2, 8'hFB); rd(2, d); chk(d == 3, "R2 prescale readback", d, 3);
    wr(14, 8'h77); rd(14, d); chk(d == 8'h77, "R2 period readback", d, 8'h77);
    wr(18, 8'h33); rd(18, d); chk(d == 8'h33, "R2 duty readback", d, 8'h33);
    rd(31, d); chk(d == 0, "R2 unmapped reads zero", d, 0);

    // R4 R5: first tick exactly 8 edges after enabling from idle, k=3
    wr(9, 10); wr(17, 3);
    cycles(20);
    wr(0, 8'h02);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (pwm_o[1] && n == 0) n = i;
    end
    chk(n == 8, "R4 R5 first tick after idle", n, 8);

    // R3 R6: period 6, duty 2 at k=0 and k=1
    wr(0, 0); wr(2, 0); wr(9, 6); wr(17, 2); wr(0, 8'h02);
    cycles(20);
    count_high(1, 60, hi); chk(hi == 20, "R6 duty 2 of 6 k=0", hi, 20);
    wr(2, 1); cycles(30);
    count_high(1, 120, hi); chk(hi == 40, "R3 duty 2 of 6 k=1", hi, 40);

    // R10: duty >= period, duty 0
    wr(0, 0); wr(2, 0);
    wr(11, 4); wr(19, 9); wr(13, 5); wr(21, 0);
    wr(0, 8'h28); cycles(10);
    count_high(3, 40, hi); chk(hi == 40, "R10 duty above period", hi, 40);
    count_high(5, 40, hi); chk(hi == 0, "R10 duty zero", hi, 0);

    // R5: k=7, output must wait for the tick
    wr(0, 0); wr(2, 7); wr(8, 5); wr(16, 2);
    wr(0, 8'h01); cycles(20);
    chk(pwm_o[0] == 0, "R5 held low before tick", pwm_o[0], 0);
    cycles(300);

    // R8 R9: joined pair 0, period 300 duty 100
    wr(0, 0); wr(2, 0);
    wr(8, 8'h01); wr(9, 8'h2C); wr(16, 8'h00); wr(17, 8'h64);
    wr(1, 1);
    wr(0, 8'h01); cycles(5);
    chk(pwm_o == 0, "R9 even enable ignored when joined", pwm_o, 0);
    rd(0, d); chk(d == 1, "R9 even bit still stored", d, 1);
    wr(0, 8'h03); cycles(320);
    count_high(1, 600, hi); chk(hi == 200, "R8 16-bit duty 100 of 300", hi, 200);
    count_high(0, 300, hi); chk(hi == 0, "R9 even pin held low", hi, 0);

    // joined pair 3 plus split channel 2 alongside
    wr(0, 0); wr(1, 8'h08);
    wr(14, 0); wr(15, 8'h10); wr(22, 0); wr(23, 8'h04);
    wr(10, 4); wr(18, 1);
    wr(0, 8'hC4); cycles(40);
    count_high(7, 160, hi); chk(hi == 40, "R8 pair 3 duty 4 of 16", hi, 40);
    count_high(2, 160, hi); chk(hi == 40, "R6 split neighbour 1 of 4", hi, 40);
    wr(0, 0); cycles(3);
    chk(pwm_o == 0, "R7 disabled outputs low", pwm_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule